// File: doc/BRIEF.md
# Halt-State Bus Controller

This block sits beside a processor core and manages its low-power halt state. When the core executes a halt instruction it raises a one-cycle strobe. The controller then spends one cycle parking the external bus and moves into a held state. While parked or held, it stalls the core, keeps the address bus at the last address the core put out, drives the data bus low and holds every bus control strobe at its inactive high level. The system clock keeps running through all of this, so the block is plain synchronous logic. While the core runs, every bus output simply follows what the core drives.

The halt state ends on a wake source. Interrupt-type sources resume the core without a reset, and the controller hands back the program counter value captured when the halt was taken. These sources are a non-maskable interrupt, a maskable interrupt when interrupts are globally enabled, and a watchdog expiry configured for NMI. Reset-type sources are the external reset pin going low, a debug reset command, and a watchdog expiry configured for reset. They return the controller to the running state from any state and raise a one-cycle core reset. A wake that arrives during the parking cycle cancels the halt.

Top module: `halt_bus_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycles after it, the block is running: `core_stall`, `core_rst` and `resume_vld` are 0.
- R2: A `halt_req` accepted while running makes `core_stall` 1 from the next cycle on. It stays 1 until a wake source is seen.
- R3: Whenever `core_stall` is 1, `data_out` is all zeros and `data_oe` is 1.
- R4: Whenever `core_stall` is 1, every bit of `bus_ctl_n` is 1.
- R5: Whenever `core_stall` is 1, `addr_out` equals the `cur_addr` of the cycle in which `halt_req` was accepted, whatever `cur_addr` does afterwards.
- R6: An interrupt-type wake while stalled clears `core_stall` on the next cycle. In that same cycle it raises `resume_vld` for exactly one cycle, with `resume_pc` equal to the `next_pc` sampled when the halt was accepted.
- R7: `irq_req` wakes the core only while `irq_glb_en` is 1. With `irq_glb_en` at 0 the core stays stalled.
- R8: `wdt_act` encodes the watchdog action as 01 = NMI and 10 = reset; 00 and 11 mean no wake. `wdt_expire` with 01 wakes as an interrupt. With 10 it wakes as a reset. With 00 or 11 it leaves the core stalled.
- R9: A reset-type source seen in any state (`ext_rst_pin_n` low, `dbg_rst_cmd`, or a watchdog expiry with action 10) makes `core_stall` 0 and `core_rst` 1 on the next cycle. `resume_vld` stays 0.
- R10: A wake source present during the parking cycle (the first stalled cycle) makes `core_stall` 0 on the following cycle.
- R11: While running, `addr_out`, `data_out`, `data_oe` and `bus_ctl_n` equal `cur_addr`, `core_data`, `core_data_oe` and `core_ctl_n` in the same cycle.
- R12: `halt_req` is ignored while a reset-type source is present and while already stalled. `core_stall` and `addr_out` are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, keeps running while halted |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt_req | input | 1 | One-cycle halt instruction strobe from the core |
| cur_addr | input | ADDR_W | Address the core is driving this cycle |
| next_pc | input | ADDR_W | Program counter to resume at |
| core_data | input | DATA_W | Data bus value from the core |
| core_data_oe | input | 1 | Core data bus output enable |
| core_ctl_n | input | CS_W+6 | Core bus control strobes, active low |
| nmi_req | input | 1 | Non-maskable interrupt |
| irq_req | input | 1 | Maskable interrupt |
| irq_glb_en | input | 1 | Global interrupt enable |
| ext_rst_pin_n | input | 1 | External reset pin, active low, sampled |
| wdt_expire | input | 1 | Watchdog timeout strobe |
| wdt_act | input | 2 | Configured watchdog action |
| dbg_rst_cmd | input | 1 | Debug reset command |
| core_stall | output | 1 | Holds the core idle and the program counter still |
| core_rst | output | 1 | One-cycle reset to the core on a reset-type wake |
| resume_vld | output | 1 | One-cycle pulse on an interrupt-type wake |
| resume_pc | output | ADDR_W | Program counter captured at halt entry |
| addr_out | output | ADDR_W | External address bus |
| data_out | output | DATA_W | External data bus value |
| data_oe | output | 1 | External data bus output enable |
| bus_ctl_n | output | CS_W+6 | External control strobes, active low |

## Verification
The bench goes after the parking cycle, where a wake must cancel the halt. A design that ignored this wake would strand the core in the held state with a pending interrupt. It drives all four watchdog action codes while halted, because a decoder that treats any expiry as a wake would release the core on a flag-only timeout. Masked interrupts and the address bus are watched across long halts with `cur_addr` changing underneath. A frozen-address register that kept loading, or an ungated interrupt, shows up there as a moving bus or an early wake. Halt strobes arriving together with a reset, or while already halted, are also driven, because a design that re-captured on them would lose the resume address.

// File: rtl/halt_pkg.sv
package halt_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PARK = 2'd1,
    ST_HALT = 2'd2
  } halt_st_e;

  typedef enum logic [1:0] {
    WDA_FLAG  = 2'd0,
    WDA_NMI   = 2'd1,
    WDA_RST   = 2'd2,
    WDA_SPARE = 2'd3
  } wdt_act_e;

  localparam int unsigned FIXED_CTL = 6;

endpackage

// File: rtl/halt_rst_sync.sv
module halt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/halt_wake_decode.sv
module halt_wake_decode
  import halt_pkg::*;
(
  input  logic       nmi_req,
  input  logic       irq_req,
  input  logic       irq_glb_en,
  input  logic       ext_rst_pin_n,
  input  logic       wdt_expire,
  input  logic [1:0] wdt_act,
  input  logic       dbg_rst_cmd,
  output logic       wake_int,
  output logic       wake_rst
);
  wdt_act_e act;
  logic     wdt_nmi;
  logic     wdt_rst;

  always_comb begin
    act     = wdt_act_e'(wdt_act);
    wdt_nmi = 1'b0;
    wdt_rst = 1'b0;
    if (wdt_expire) begin
      unique case (act)
        WDA_NMI: wdt_nmi = 1'b1;
        WDA_RST: wdt_rst = 1'b1;
        default: ;
      endcase
    end
    wake_rst = !ext_rst_pin_n || dbg_rst_cmd || wdt_rst;
    wake_int = nmi_req || (irq_req && irq_glb_en) || wdt_nmi;
  end
endmodule

// File: rtl/halt_fsm.sv
module halt_fsm
  import halt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     halt_req,
  input  logic     wake_int,
  input  logic     wake_rst,
  output halt_st_e state,
  output logic     cap_en,
  output logic     core_rst,
  output logic     resume_vld
);
  halt_st_e st_q, st_d;
  logic     rst_pulse_d, rst_pulse_q;
  logic     res_pulse_d, res_pulse_q;

  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (halt_req && !wake_rst) begin
          st_d   = ST_PARK;
          cap_en = 1'b1;
        end
      end
      ST_PARK, ST_HALT: begin
        if (wake_int || wake_rst) st_d = ST_RUN;
        else                      st_d = ST_HALT;
      end
      default: st_d = ST_RUN;
    endcase
    if (wake_rst) st_d = ST_RUN;
    rst_pulse_d = wake_rst;
    res_pulse_d = (st_q != ST_RUN) && wake_int && !wake_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_RUN;
      rst_pulse_q <= 1'b0;
      res_pulse_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      rst_pulse_q <= rst_pulse_d;
      res_pulse_q <= res_pulse_d;
    end
  end

  assign state      = st_q;
  assign core_rst   = rst_pulse_q;
  assign resume_vld = res_pulse_q;
endmodule

// File: rtl/halt_bus_park.sv
module halt_bus_park
  import halt_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CTL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  halt_st_e          state,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [DATA_W-1:0] core_data,
  input  logic              core_data_oe,
  input  logic [CTL_W-1:0]  core_ctl_n,
  output logic              stall,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic [CTL_W-1:0]  bus_ctl_n,
  output logic [ADDR_W-1:0] resume_pc
);
  logic              run_cyc;
  logic              addr_en;
  logic [ADDR_W-1:0] addr_hold_q, addr_hold_d;
  logic [ADDR_W-1:0] pc_hold_q, pc_hold_d;

  always_comb begin
    run_cyc     = (state == ST_RUN);
    addr_en     = run_cyc;
    addr_hold_d = addr_en ? cur_addr : addr_hold_q;
    pc_hold_d   = cap_en ? next_pc : pc_hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_hold_q <= '0;
      pc_hold_q   <= '0;
    end else begin
      addr_hold_q <= addr_hold_d;
      pc_hold_q   <= pc_hold_d;
    end
  end

  always_comb begin
    stall = !run_cyc;
    if (run_cyc) begin
      addr_out  = cur_addr;
      data_out  = core_data;
      data_oe   = core_data_oe;
      bus_ctl_n = core_ctl_n;
    end else begin
      addr_out  = addr_hold_q;
      data_out  = '0;
      data_oe   = 1'b1;
      bus_ctl_n = '1;
    end
  end

  assign resume_pc = pc_hold_q;
endmodule

// File: rtl/halt_bus_ctrl.sv
module halt_bus_ctrl
  import halt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CS_W      = 4,
  parameter int unsigned RST_SYNC  = 2,
  localparam int unsigned CTL_W    = CS_W + FIXED_CTL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [DATA_W-1:0] core_data,
  input  logic              core_data_oe,
  input  logic [CTL_W-1:0]  core_ctl_n,
  input  logic              nmi_req,
  input  logic              irq_req,
  input  logic              irq_glb_en,
  input  logic              ext_rst_pin_n,
  input  logic              wdt_expire,
  input  logic [1:0]        wdt_act,
  input  logic              dbg_rst_cmd,
  output logic              core_stall,
  output logic              core_rst,
  output logic              resume_vld,
  output logic [ADDR_W-1:0] resume_pc,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic [CTL_W-1:0]  bus_ctl_n
);
  logic     rst_sync_n;
  logic     wake_int;
  logic     wake_rst;
  logic     cap_en;
  halt_st_e state;

  halt_rst_sync #(.STAGES(RST_SYNC)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  halt_wake_decode u_wake (
    .nmi_req       (nmi_req),
    .irq_req       (irq_req),
    .irq_glb_en    (irq_glb_en),
    .ext_rst_pin_n (ext_rst_pin_n),
    .wdt_expire    (wdt_expire),
    .wdt_act       (wdt_act),
    .dbg_rst_cmd   (dbg_rst_cmd),
    .wake_int      (wake_int),
    .wake_rst      (wake_rst)
  );

  halt_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .halt_req   (halt_req),
    .wake_int   (wake_int),
    .wake_rst   (wake_rst),
    .state      (state),
    .cap_en     (cap_en),
    .core_rst   (core_rst),
    .resume_vld (resume_vld)
  );

  halt_bus_park #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CTL_W  (CTL_W)
  ) u_park (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .state        (state),
    .cap_en       (cap_en),
    .cur_addr     (cur_addr),
    .next_pc      (next_pc),
    .core_data    (core_data),
    .core_data_oe (core_data_oe),
    .core_ctl_n   (core_ctl_n),
    .stall        (core_stall),
    .addr_out     (addr_out),
    .data_out     (data_out),
    .data_oe      (data_oe),
    .bus_ctl_n    (bus_ctl_n),
    .resume_pc    (resume_pc)
  );
endmodule

// File: rtl/halt_bus_ctrl_chk.sv
module halt_bus_ctrl_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CTL_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt_req,
  input logic              nmi_req,
  input logic              irq_req,
  input logic              irq_glb_en,
  input logic              ext_rst_pin_n,
  input logic              wdt_expire,
  input logic [1:0]        wdt_act,
  input logic              dbg_rst_cmd,
  input logic              core_stall,
  input logic              core_rst,
  input logic              resume_vld,
  input logic [ADDR_W-1:0] addr_out,
  input logic [DATA_W-1:0] data_out,
  input logic              data_oe,
  input logic [CTL_W-1:0]  bus_ctl_n
);
  logic rst_src;
  logic quiet;

  always_comb begin
    rst_src = !ext_rst_pin_n || dbg_rst_cmd || (wdt_expire && wdt_act == 2'b10);
    quiet   = !rst_src && !nmi_req && !(irq_req && irq_glb_en) && !wdt_expire;
  end

  // R2
  halt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_stall && halt_req && !rst_src) |=> core_stall);

  // R3
  data_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> (data_out == '0 && data_oe));

  // R4
  ctl_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> (&bus_ctl_n));

  // R5
  addr_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall && $past(core_stall)) |-> $stable(addr_out));

  // R6
  resume_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_vld |-> (!core_stall && !core_rst && $past(core_stall)));

  // R7
  stay_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall && quiet) |=> core_stall);

  // R9
  rst_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_src |=> (!core_stall && core_rst && !resume_vld));

  // R10
  park_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(core_stall) && nmi_req) |=> !core_stall);
endmodule

bind halt_bus_ctrl halt_bus_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CTL_W  (CTL_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .halt_req      (halt_req),
  .nmi_req       (nmi_req),
  .irq_req       (irq_req),
  .irq_glb_en    (irq_glb_en),
  .ext_rst_pin_n (ext_rst_pin_n),
  .wdt_expire    (wdt_expire),
  .wdt_act       (wdt_act),
  .dbg_rst_cmd   (dbg_rst_cmd),
  .core_stall    (core_stall),
  .core_rst      (core_rst),
  .resume_vld    (resume_vld),
  .addr_out      (addr_out),
  .data_out      (data_out),
  .data_oe       (data_oe),
  .bus_ctl_n     (bus_ctl_n)
);

// File: tb/halt_bus_ctrl_tb.sv
`timescale 1ns/1ps
module halt_bus_ctrl_tb;
  localparam int AW = 24;
  localparam int DW = 8;
  localparam int CW = 10;
  localparam real TCLK = 8.0;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          halt_req, core_data_oe, nmi_req, irq_req, irq_glb_en;
  logic          ext_rst_pin_n, wdt_expire, dbg_rst_cmd;
  logic [1:0]    wdt_act;
  logic [AW-1:0] cur_addr, next_pc;
  logic [DW-1:0] core_data;
  logic [CW-1:0] core_ctl_n;
  logic          core_stall, core_rst, resume_vld, data_oe;
  logic [AW-1:0] resume_pc, addr_out;
  logic [DW-1:0] data_out;
  logic [CW-1:0] bus_ctl_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench reference state: 0 run, 1 park, 2 halted
  int            m_st;
  logic [AW-1:0] m_addr, m_pc;
  bit            m_rst, m_res;

  always #(TCLK/2) clk = ~clk;

  halt_bus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .cur_addr(cur_addr),
    .next_pc(next_pc), .core_data(core_data), .core_data_oe(core_data_oe),
    .core_ctl_n(core_ctl_n), .nmi_req(nmi_req), .irq_req(irq_req),
    .irq_glb_en(irq_glb_en), .ext_rst_pin_n(ext_rst_pin_n),
    .wdt_expire(wdt_expire), .wdt_act(wdt_act), .dbg_rst_cmd(dbg_rst_cmd),
    .core_stall(core_stall), .core_rst(core_rst), .resume_vld(resume_vld),
    .resume_pc(resume_pc), .addr_out(addr_out), .data_out(data_out),
    .data_oe(data_oe), .bus_ctl_n(bus_ctl_n)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit rst_src();
    return !ext_rst_pin_n || dbg_rst_cmd || (wdt_expire && wdt_act == 2'b10);
  endfunction

  function automatic bit int_src();
    return nmi_req || (irq_req && irq_glb_en) || (wdt_expire && wdt_act == 2'b01);
  endfunction

  function automatic void model_step();
    bit r, i;
    r = rst_src();
    i = int_src();
    m_rst = r;
    m_res = (m_st != 0) && i && !r;
    if (r) m_st = 0;
    else if (m_st == 0) begin
      if (halt_req) begin m_st = 1; m_addr = cur_addr; m_pc = next_pc; end
    end else m_st = i ? 0 : 2;
  endfunction

  task automatic quiet_inputs();
    halt_req = 0; nmi_req = 0; irq_req = 0; irq_glb_en = 0;
    ext_rst_pin_n = 1; wdt_expire = 0; wdt_act = 2'b00; dbg_rst_cmd = 0;
    cur_addr = AW'($urandom); next_pc = AW'($urandom);
    core_data = DW'($urandom); core_data_oe = 1'($urandom);
    core_ctl_n = CW'($urandom);
  endtask

  // inputs already set at a negedge; check outputs, then clock once
  task automatic cycle();
    #1;
    chk("R2", "core_stall", 32'(core_stall), 32'(m_st != 0));
    if (m_st != 0) begin
      chk("R3", "data_out/oe", {23'd0, data_oe, data_out}, {23'd0, 1'b1, 8'h00});
      chk("R4", "bus_ctl_n", 32'(bus_ctl_n), 32'({CW{1'b1}}));
      chk("R5", "addr_out", 32'(addr_out), 32'(m_addr));
    end else begin
      chk("R11", "addr_out", 32'(addr_out), 32'(cur_addr));
      chk("R11", "data", {23'd0, data_oe, data_out}, {23'd0, core_data_oe, core_data});
      chk("R11", "bus_ctl_n", 32'(bus_ctl_n), 32'(core_ctl_n));
    end
    chk("R9", "core_rst", 32'(core_rst), 32'(m_rst));
    chk("R6", "resume_vld", 32'(resume_vld), 32'(m_res));
    if (m_res) chk("R6", "resume_pc", 32'(resume_pc), 32'(m_pc));
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic enter_halt();
    quiet_inputs(); halt_req = 1; cycle();
    quiet_inputs(); cycle();
  endtask

  initial begin
    void'($urandom(32'd20240917));
    m_st = 0; m_addr = '0; m_pc = '0; m_rst = 0; m_res = 0;
    rst_n = 0;
    quiet_inputs();
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "stall in reset", 32'(core_stall), 0);
    chk("R1", "core_rst in reset", 32'(core_rst), 0);
    chk("R1", "resume_vld in reset", 32'(resume_vld), 0);
    @(negedge clk);
    rst_n = 1;
    repeat (3) begin quiet_inputs(); cycle(); end
    chk("R1", "stall after reset", 32'(core_stall), 0);

    // R5 R7: address held, masked irq ignored, then enabled irq wakes
    enter_halt();
    for (int k = 0; k < 4; k++) begin quiet_inputs(); irq_req = 1; cycle(); end
    chk("R7", "masked irq keeps stall", 32'(core_stall), 1);
    quiet_inputs(); irq_req = 1; irq_glb_en = 1; cycle();
    chk("R7", "enabled irq wakes", 32'(core_stall), 0);
    chk("R6", "resume pulse", 32'(resume_vld), 1);

    // R8 watchdog actions
    enter_halt();
    quiet_inputs(); wdt_expire = 1; wdt_act = 2'b00; cycle();
    chk("R8", "flag action no wake", 32'(core_stall), 1);
    quiet_inputs(); wdt_expire = 1; wdt_act = 2'b11; cycle();
    chk("R8", "code 11 no wake", 32'(core_stall), 1);
    quiet_inputs(); wdt_expire = 1; wdt_act = 2'b01; cycle();
    chk("R8", "nmi action wakes", 32'(core_stall), 0);
    chk("R8", "nmi action resumes", 32'(resume_vld), 1);
    enter_halt();
    quiet_inputs(); wdt_expire = 1; wdt_act = 2'b10; cycle();
    chk("R8", "reset action wakes", 32'(core_stall), 0);
    chk("R8", "reset action core_rst", 32'(core_rst), 1);

    // R9 reset pin and debug reset while halted
    enter_halt();
    quiet_inputs(); ext_rst_pin_n = 0; cycle();
    chk("R9", "pin reset wakes", {30'd0, core_stall, core_rst}, 32'b01);
    enter_halt();
    quiet_inputs(); dbg_rst_cmd = 1; cycle();
    chk("R9", "debug reset wakes", {30'd0, core_stall, core_rst, resume_vld}, 32'b010);

    // R10 wake during the parking cycle cancels
    quiet_inputs(); halt_req = 1; cycle();
    quiet_inputs(); nmi_req = 1; cycle();
    chk("R10", "park cancel", 32'(core_stall), 0);

    // R12 halt_req with reset source, and while halted
    quiet_inputs(); halt_req = 1; dbg_rst_cmd = 1; cycle();
    chk("R12", "halt with reset ignored", 32'(core_stall), 0);
    enter_halt();
    quiet_inputs(); halt_req = 1; cycle();
    chk("R12", "halt while halted", {31'd0, core_stall}, 1);
    chk("R12", "addr kept", 32'(addr_out), 32'(m_addr));
    quiet_inputs(); nmi_req = 1; cycle();
    chk("R12", "original pc kept", 32'(resume_pc), 32'(m_pc));

    // constrained random
    for (int n = 0; n < 5000; n++) begin
      quiet_inputs();
      halt_req      = ($urandom_range(99) < 30);
      nmi_req       = ($urandom_range(99) < 4);
      irq_req       = ($urandom_range(99) < 10);
      irq_glb_en    = 1'($urandom);
      ext_rst_pin_n = !($urandom_range(99) < 2);
      dbg_rst_cmd   = ($urandom_range(99) < 2);
      wdt_expire    = ($urandom_range(99) < 6);
      wdt_act       = 2'($urandom);
      cycle();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule